// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block collects the level-sensitive interrupt pins (INTA to INTD) of a few PCI device slots and steers them onto the sixteen inputs of a legacy interrupt controller. Each pin is first rotated by the slot's device number onto one of four shared interrupt lines, called A to D here. Each shared line carries the OR of every pin that rotates onto it. Four programmable steering registers, one per shared line, then pick which controller input each line drives. A steering value of sixteen or more parks its line, so that line drives no controller input.

The steering registers sit behind a plain byte-wide register port. A write takes effect on the same clock edge that captures it. A read returns the addressed register combinationally. The register port and the interrupt pins are control and level signals, so they carry no valid/ready handshake and never apply back-pressure. The block keeps a registered 64-bit level map, one bit per (controller input, shared line) pair. Each controller output is the OR of its four map bits.

Top module: `irqr_top`

## Requirements
- R1: Device pin p (0 = INTA to 3 = INTD) of slot s is input bit dev_int[4*s+p]. The slot's device number is FIRST_DEV+s. The pin lands on shared line (p + device number - 1) mod 4, where line 0 is A and line 3 is D.
- R2: The steering registers for lines A, B, C and D live at byte addresses ROUTE_BASE+0 to ROUTE_BASE+3 (default 0x60 to 0x63). A read returns exactly the last value written. A read of any other address returns 0x00. A write to any other address changes no register and no output.
- R3: A steering value of 16 or more disconnects its line, and that line drives no output whatever its level.
- R4: Output irq_out[k] is the OR of all shared lines whose steering value is below 16 and whose low four bits equal k. Several lines may share one output.
- R5: Reset is asynchronous and active low. While it is active and after it, every steering register reads 0x80 and every output is 0.
- R6: Outputs are registered. Pin levels and register writes present at a rising clock edge show on irq_out just after that edge and not before.
- R7: A register write recomputes every output from the current line levels. A line that is high moves from its old output to its new output on the write's edge.
- R8: A shared line stays high while any pin that rotates onto it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_int | input | 4*SLOTS | Device interrupt levels, bit 4*slot+pin, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_out | output | OUT_CNT | Controller input levels |

## Verification
A vector table pairs steering settings with pin patterns, and each pattern is chosen to separate one kind of fault. Single pins from different slots catch a wrong rotation or slot offset. Several lines steered to one output catch a missing OR. A parked line mixed with live ones, including one parked by an upper bit while its low bits look valid, catches a bad disconnect test. Directed tests then check the registered timing, a line moving when it is re-steered, two pins holding one line, writes to neighbouring addresses being ignored, and the reset values.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int LINES    = 4;
  localparam int LINE_IW  = $clog2(LINES);
  localparam int ROUTE_W  = 8;
  localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;

  typedef logic [LINES-1:0][ROUTE_W-1:0] route_arr_t;

  // shared line index for a pin on a given device number
  function automatic int swz_line(input int pin, input int dev);
    int v;
    v = (pin + dev - 1) % LINES;
    if (v < 0) v = v + LINES;
    return v;
  endfunction
endpackage

// File: rtl/irqr_swizzle.sv
module irqr_swizzle
  import irqr_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int FIRST_DEV = 1
) (
  input  logic [4*SLOTS-1:0] dev_int,
  output logic [LINES-1:0]   line_lvl
);
  always_comb begin
    line_lvl = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int p = 0; p < 4; p++) begin
        line_lvl[swz_line(p, FIRST_DEV + s)] =
          line_lvl[swz_line(p, FIRST_DEV + s)] | dev_int[4*s+p];
      end
    end
  end
endmodule

// File: rtl/irqr_route_regs.sv
module irqr_route_regs
  import irqr_pkg::*;
#(
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [ROUTE_W-1:0] reg_wdata,
  output logic [ROUTE_W-1:0] reg_rdata,
  output route_arr_t         route_q,
  output route_arr_t         route_nxt
);
  logic [7:0] offs;
  logic       hit;

  assign offs = reg_addr - ROUTE_BASE;
  assign hit  = (int'(offs) < LINES);

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      if (reg_wr && hit && (offs[LINE_IW-1:0] == LINE_IW'(l)))
        route_nxt[l] = reg_wdata;
      else
        route_nxt[l] = route_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) route_q[l] <= ROUTE_RST;
    end else begin
      route_q <= route_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) reg_rdata = route_q[offs[LINE_IW-1:0]];
  end
endmodule

// File: rtl/irqr_level_map.sv
module irqr_level_map
  import irqr_pkg::*;
#(
  parameter int OUT_CNT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   line_lvl,
  input  route_arr_t         route_nxt,
  output logic [OUT_CNT-1:0] irq_out
);
  localparam int MAP_W = OUT_CNT * LINES;
  localparam int OUT_W = (OUT_CNT > 1) ? $clog2(OUT_CNT) : 1;

  logic [MAP_W-1:0] lvl_d, lvl_q;

  always_comb begin
    for (int o = 0; o < OUT_CNT; o++) begin
      for (int l = 0; l < LINES; l++) begin
        lvl_d[o*LINES+l] = line_lvl[l]
                         && (int'(route_nxt[l]) < OUT_CNT)
                         && (route_nxt[l][OUT_W-1:0] == OUT_W'(o));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  for (genvar o = 0; o < OUT_CNT; o++) begin : g_out
    assign irq_out[o] = |lvl_q[o*LINES +: LINES];
  end
endmodule

// File: rtl/irqr_top.sv
module irqr_top
  import irqr_pkg::*;
#(
  parameter int         SLOTS      = 4,
  parameter int         FIRST_DEV  = 1,
  parameter int         OUT_CNT    = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4*SLOTS-1:0] dev_int,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [OUT_CNT-1:0] irq_out
);
  logic [LINES-1:0] line_lvl;
  route_arr_t       route_q;
  route_arr_t       route_nxt;

  irqr_swizzle #(.SLOTS(SLOTS), .FIRST_DEV(FIRST_DEV)) u_swz (
    .dev_int  (dev_int),
    .line_lvl (line_lvl)
  );

  irqr_route_regs #(.ROUTE_BASE(ROUTE_BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .route_q   (route_q),
    .route_nxt (route_nxt)
  );

  irqr_level_map #(.OUT_CNT(OUT_CNT)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_lvl  (line_lvl),
    .route_nxt (route_nxt),
    .irq_out   (irq_out)
  );
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irqr_pkg::*;
#(
  parameter int         SLOTS      = 4,
  parameter int         OUT_CNT    = 16,
  parameter logic [7:0] ROUTE_BASE = 8'h60
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4*SLOTS-1:0] dev_int,
  input logic               reg_wr,
  input logic [7:0]         reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [OUT_CNT-1:0] irq_out,
  input route_arr_t         route_q
);
  logic [7:0] chk_offs;
  logic       chk_hit;
  logic       all_parked;

  assign chk_offs = reg_addr - ROUTE_BASE;
  assign chk_hit  = (int'(chk_offs) < LINES);

  always_comb begin
    all_parked = 1'b1;
    for (int l = 0; l < LINES; l++)
      if (int'(route_q[l]) < OUT_CNT) all_parked = 1'b0;
  end

  AST_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_int == '0) |=> (irq_out == '0)); // R4

  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_out) <= LINES)); // R4

  AST_RD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_hit) |-> (reg_rdata == 8'h00)); // R2

  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && chk_hit) |=>
      (route_q[$past(chk_offs[LINE_IW-1:0])] == $past(reg_wdata))); // R2

  AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && all_parked) |=> (irq_out == '0)); // R3
endmodule

bind irqr_top irqr_checker #(
  .SLOTS(SLOTS), .OUT_CNT(OUT_CNT), .ROUTE_BASE(ROUTE_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_int   (dev_int),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .route_q   (route_q)
);

// File: tb/irqr_top_tb_top.sv
module irqr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {route A, B, C, D, dev_int, expected irq_out}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'd3, 8'd5, 8'd9, 8'd14, 16'h0001, 16'h0008},
    {8'd3, 8'd5, 8'd9, 8'd14, 16'h0020, 16'h0200},
    {8'd3, 8'd5, 8'd9, 8'd14, 16'h8000, 16'h0200},
    {8'd3, 8'd5, 8'd9, 8'd14, 16'h0080, 16'h0008},
    {8'd7, 8'd7, 8'd7, 8'd7,  16'h0002, 16'h0080},
    {8'd0, 8'h10, 8'd15, 8'h80, 16'h0006, 16'h8000},
    {8'd0, 8'h10, 8'd15, 8'h80, 16'hFFFF, 16'h8001},
    {8'd4, 8'd4, 8'd4, 8'd4,  16'h0000, 16'h0000},
    {8'd1, 8'd1, 8'd1, 8'd1,  16'h1000, 16'h0002}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_int = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] irq_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqr_top dut_i (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R5: reset state
    #(CLK_PERIOD*2 + 2);
    chk("R5 out in reset", irq_out, 16'h0000);
    rd_chk("R5 route A in reset", 8'h60, 8'h80);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int l = 0; l < 4; l++) rd_chk("R5 route after reset", 8'h60 + 8'(l), 8'h80);
    dev_int = 16'hFFFF;
    @(negedge clk);
    chk("R5 all parked after reset", irq_out, 16'h0000);
    dev_int = '0;

    // table walk: R1 R4 R3 R2
    for (int i = 0; i < NVEC; i++) begin
      for (int l = 0; l < 4; l++) wr(8'h60 + 8'(l), VEC[i][63-8*l -: 8]);
      for (int l = 0; l < 4; l++) rd_chk("R2 readback", 8'h60 + 8'(l), VEC[i][63-8*l -: 8]);
      dev_int = VEC[i][31:16];
      @(negedge clk);
      chk($sformatf("R1/R4/R3 vector %0d", i), irq_out, VEC[i][15:0]);
    end

    // R6: registered timing
    dev_int = '0;
    wr(8'h60, 8'd2); wr(8'h61, 8'h80); wr(8'h62, 8'h80); wr(8'h63, 8'h80);
    @(negedge clk);
    dev_int = 16'h0001;
    #1;
    chk("R6 no change before edge", irq_out, 16'h0000);
    @(negedge clk);
    chk("R6 change after edge", irq_out, 16'h0004);

    // R7: re-steer moves the level on the write edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 8'd6;
    #1;
    chk("R7 before write edge", irq_out, 16'h0004);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 moved after write", irq_out, 16'h0040);

    // R3: upper bits park even with valid low nibble
    wr(8'h60, 8'h13);
    chk("R3 value 0x13 parks", irq_out, 16'h0000);
    wr(8'h60, 8'h96);
    chk("R3 value 0x96 parks", irq_out, 16'h0000);
    wr(8'h60, 8'd6);

    // R8: two pins on line A (slot0 INTA, slot1 INTD)
    dev_int = 16'h0081;
    @(negedge clk);
    chk("R8 both high", irq_out, 16'h0040);
    dev_int = 16'h0080;
    @(negedge clk);
    chk("R8 one remains", irq_out, 16'h0040);
    dev_int = 16'h0000;
    @(negedge clk);
    chk("R8 none high", irq_out, 16'h0000);

    // R2: writes beside the range are ignored
    dev_int = 16'h0001;
    wr(8'h64, 8'd1);
    wr(8'h5F, 8'd1);
    chk("R2 outside write no output effect", irq_out, 16'h0040);
    rd_chk("R2 A unchanged", 8'h60, 8'd6);
    rd_chk("R2 D unchanged", 8'h63, 8'h80);
    rd_chk("R2 read 0x64 zero", 8'h64, 8'h00);
    rd_chk("R2 read 0x5F zero", 8'h5F, 8'h00);

    // R5: reset mid-run clears outputs and routes
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R5 async clear", irq_out, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R5 route A after second reset", 8'h60, 8'h80);

    finish_run();
  end
endmodule